// File: doc/BRIEF.md
# Data-driven datapath processing element

This block is a single word-wide processing element meant to be tiled into a reconfigurable array. A neighbour hands it operands through two single-entry input registers. It hands results onward through two single-entry output registers. Every one of these four registers uses a valid/ready handshake. Nothing schedules the element from outside. Once an operator code has been loaded, the element fires as soon as the operands that operator needs are present and the output registers it will write are empty. It then stays busy for a fixed number of cycles and writes the result.

Add, subtract and the three bitwise operators are computed directly by a small ALU. A pass operator copies the first operand, so the element can serve as a routing hop. Multiplication is done by a microsequence of shift-and-add steps that keeps the low word of the unsigned product. A configuration port loads the operator and a two-bit route mask. The mask selects which output registers receive the result. The port is only honoured while the element is idle.

Top module: `dp_cell`

## Requirements
- R1: After reset both output valids are low, both input readies are high, and the loaded operator is the no-op (code 0) with route mask 2'b01.
- R2: Operator codes 1 to 5 give, modulo 2^32: 1 = A+B, 2 = A-B, 3 = A AND B, 4 = A OR B, 5 = A XOR B.
- R3: For an ALU operator (codes 1 to 6), the output valid rises exactly ALU_STEPS+1 clock edges after the edge that captures the last needed operand, provided the element is idle and the output registers are empty (5 edges by default).
- R4: Operator code 7 gives the low 32 bits of the unsigned product A*B.
- R5: For multiply, the output valid rises exactly MUL_STEPS+1 edges after the edge that captures the last operand (23 edges by default).
- R6: Nothing fires until every operand the operator needs has been captured. Each input register holds one word: its ready is low while it is full, and it goes high again only when the element consumes that word.
- R7: Operands that arrive while the element is busy are held and not consumed. Back-to-back multiplies with one output draining freely produce results MUL_STEPS+2 edges apart.
- R8: An output register holds its valid and data unchanged until ready is seen. While any output register in the route mask is full, nothing fires and held operands stay unconsumed.
- R9: Operator code 6 copies A to the outputs without needing or consuming B.
- R10: A configuration load while the element is busy is ignored. A load while idle takes effect for the next firing.
- R11: Bit 0 of the route mask sends the result to output X and bit 1 sends it to output Y. An output that is not selected stays invalid.
- R12: Code 0 and codes 8 to 15 never fire, so captured operands stay held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load operator and route (honoured only while idle) |
| cfg_op | input | 4 | Operator code |
| cfg_route | input | 2 | Output select mask (bit 0 = X, bit 1 = Y) |
| a_valid | input | 1 | Operand A offered |
| a_ready | output | 1 | Operand A register empty |
| a_data | input | 32 | Operand A word |
| b_valid | input | 1 | Operand B offered |
| b_ready | output | 1 | Operand B register empty |
| b_data | input | 32 | Operand B word |
| x_valid | output | 1 | Output X holds a result |
| x_ready | input | 1 | Downstream takes X |
| x_data | output | 32 | Output X word |
| y_valid | output | 1 | Output Y holds a result |
| y_ready | input | 1 | Downstream takes Y |
| y_data | output | 32 | Output Y word |

## Verification
A wrong busy counter shows up as a result valid that rises one or more edges off the expected count, and this is visible on the first operation. A stuck multiply step or a bad partial-product shift corrupts the product. Operand patterns with the top bit set or with all ones expose it on the first multiply that uses them. A full flag that is cleared at the wrong moment shows up at once: a ready comes back early, or a held operand is fired twice. A configuration register that is not frozen during a busy period shows up in the next result's value or in the output it lands on.

// File: rtl/dp_cell_pkg.sv
package dp_cell_pkg;

   typedef enum logic [3:0] {
      OP_NOP  = 4'd0,
      OP_ADD  = 4'd1,
      OP_SUB  = 4'd2,
      OP_AND  = 4'd3,
      OP_OR   = 4'd4,
      OP_XOR  = 4'd5,
      OP_PASS = 4'd6,
      OP_MUL  = 4'd7
   } dp_op_e;

   function automatic logic op_fires(input logic [3:0] op);
      return (op >= 4'd1) && (op <= 4'd7);
   endfunction

   function automatic logic op_uses_b(input logic [3:0] op);
      return op_fires(op) && (op != 4'(OP_PASS));
   endfunction

   function automatic logic op_is_mul(input logic [3:0] op);
      return op == 4'(OP_MUL);
   endfunction

endpackage

// File: rtl/dp_cell_inreg.sv
module dp_cell_inreg #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_data,
   input  logic             consume,
   output logic             full,
   output logic [WIDTH-1:0] word
);

   logic             full_q;
   logic [WIDTH-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         word_q <= '0;
      end else if (consume) begin
         full_q <= 1'b0;
      end else if (in_valid && !full_q) begin
         full_q <= 1'b1;
         word_q <= in_data;
      end
   end

   assign in_ready = !full_q;
   assign full     = full_q;
   assign word     = word_q;

endmodule

// File: rtl/dp_cell_alu.sv
module dp_cell_alu
   import dp_cell_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] y
);

   always_comb begin
      case (dp_op_e'(op))
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         default: y = a;
      endcase
   end

endmodule

// File: rtl/dp_cell_mulseq.sv
module dp_cell_mulseq #(
   parameter int WIDTH = 32,
   parameter int BPS   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             step_en,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] prod
);

   localparam int NSTEP = WIDTH / BPS;
   localparam int CW    = $clog2(NSTEP + 1);

   logic [WIDTH-1:0] acc_q, mcand_q, mpl_q, acc_nxt;
   logic [CW-1:0]    step_q;
   logic [WIDTH-1:0] part [BPS];

   for (genvar i = 0; i < BPS; i++) begin : g_part
      assign part[i] = mpl_q[i] ? (mcand_q << i) : '0;
   end

   always_comb begin
      acc_nxt = acc_q;
      for (int i = 0; i < BPS; i++) acc_nxt = acc_nxt + part[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         mcand_q <= '0;
         mpl_q   <= '0;
         step_q  <= '0;
      end else if (start) begin
         acc_q   <= '0;
         mcand_q <= a;
         mpl_q   <= b;
         step_q  <= '0;
      end else if (step_en && (step_q < CW'(NSTEP))) begin
         acc_q   <= acc_nxt;
         mcand_q <= mcand_q << BPS;
         mpl_q   <= mpl_q >> BPS;
         step_q  <= step_q + 1'b1;
      end
   end

   assign prod = acc_q;

endmodule

// File: rtl/dp_cell_outreg.sv
module dp_cell_outreg #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] word,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data
);

   logic             full_q;
   logic [WIDTH-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (load) begin
         full_q <= 1'b1;
         data_q <= word;
      end else if (full_q && out_ready) begin
         full_q <= 1'b0;
      end
   end

   assign out_valid = full_q;
   assign out_data  = data_q;

endmodule

// File: rtl/dp_cell.sv
module dp_cell
   import dp_cell_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int ALU_STEPS = 4,
   parameter int MUL_STEPS = 22,
   parameter int MUL_BPS   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic [3:0]       cfg_op,
   input  logic [1:0]       cfg_route,
   input  logic             a_valid,
   output logic             a_ready,
   input  logic [WIDTH-1:0] a_data,
   input  logic             b_valid,
   output logic             b_ready,
   input  logic [WIDTH-1:0] b_data,
   output logic             x_valid,
   input  logic             x_ready,
   output logic [WIDTH-1:0] x_data,
   output logic             y_valid,
   input  logic             y_ready,
   output logic [WIDTH-1:0] y_data
);

   localparam int NIN   = 2;
   localparam int NOUT  = 2;
   localparam int MAXST = (MUL_STEPS > ALU_STEPS) ? MUL_STEPS : ALU_STEPS;
   localparam int CNTW  = $clog2(MAXST + 1);

   if (ALU_STEPS < 1) begin : g_bad_alu
      $error("ALU_STEPS must be at least 1");
   end
   if ((MUL_BPS < 1) || (WIDTH % MUL_BPS != 0)) begin : g_bad_bps
      $error("MUL_BPS must divide WIDTH");
   end
   if (MUL_STEPS < WIDTH / MUL_BPS + 1) begin : g_bad_mul
      $error("MUL_STEPS too small for the microsequence");
   end

   logic [3:0]       cfg_op_q;
   logic [1:0]       cfg_route_q;
   logic             busy_q, is_mul_q;
   logic [CNTW-1:0]  cnt_q;
   logic [1:0]       wr_route_q;
   logic [WIDTH-1:0] res_q, alu_y, mul_p, result;
   logic             fire, wr;

   logic             in_v   [NIN];
   logic             in_r   [NIN];
   logic [WIDTH-1:0] in_d   [NIN];
   logic             in_full[NIN];
   logic [WIDTH-1:0] in_w   [NIN];
   logic             in_cons[NIN];

   logic             out_v  [NOUT];
   logic             out_r  [NOUT];
   logic [WIDTH-1:0] out_d  [NOUT];
   logic [NOUT-1:0]  out_full;

   assign in_v[0] = a_valid;
   assign in_d[0] = a_data;
   assign in_v[1] = b_valid;
   assign in_d[1] = b_data;
   assign a_ready = in_r[0];
   assign b_ready = in_r[1];

   assign out_r[0] = x_ready;
   assign out_r[1] = y_ready;
   assign x_valid  = out_v[0];
   assign x_data   = out_d[0];
   assign y_valid  = out_v[1];
   assign y_data   = out_d[1];

   // configuration, frozen while an operation is in flight
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_op_q    <= 4'(OP_NOP);
         cfg_route_q <= 2'b01;
      end else if (cfg_load && !busy_q) begin
         cfg_op_q    <= cfg_op;
         cfg_route_q <= cfg_route;
      end
   end

   for (genvar i = 0; i < NOUT; i++) begin : g_ofull
      assign out_full[i] = out_v[i];
   end

   assign fire = !busy_q && op_fires(cfg_op_q) && in_full[0]
               && (in_full[1] || !op_uses_b(cfg_op_q))
               && (cfg_route_q != 2'b00)
               && ((cfg_route_q & out_full) == 2'b00);

   assign in_cons[0] = fire;
   assign in_cons[1] = fire && op_uses_b(cfg_op_q);

   for (genvar i = 0; i < NIN; i++) begin : g_in
      dp_cell_inreg #(.WIDTH(WIDTH)) u_in (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (in_v[i]),
         .in_ready (in_r[i]),
         .in_data  (in_d[i]),
         .consume  (in_cons[i]),
         .full     (in_full[i]),
         .word     (in_w[i])
      );
   end

   dp_cell_alu #(.WIDTH(WIDTH)) u_alu (
      .op (cfg_op_q),
      .a  (in_w[0]),
      .b  (in_w[1]),
      .y  (alu_y)
   );

   dp_cell_mulseq #(.WIDTH(WIDTH), .BPS(MUL_BPS)) u_mul (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (fire && op_is_mul(cfg_op_q)),
      .step_en (busy_q && is_mul_q),
      .a       (in_w[0]),
      .b       (in_w[1]),
      .prod    (mul_p)
   );

   // step counter: result is written when the count reaches zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         is_mul_q   <= 1'b0;
         cnt_q      <= '0;
         wr_route_q <= 2'b00;
         res_q      <= '0;
      end else if (fire) begin
         busy_q     <= 1'b1;
         is_mul_q   <= op_is_mul(cfg_op_q);
         cnt_q      <= op_is_mul(cfg_op_q) ? CNTW'(MUL_STEPS - 1)
                                           : CNTW'(ALU_STEPS - 1);
         wr_route_q <= cfg_route_q;
         res_q      <= alu_y;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign wr     = busy_q && (cnt_q == '0);
   assign result = is_mul_q ? mul_p : res_q;

   for (genvar i = 0; i < NOUT; i++) begin : g_out
      dp_cell_outreg #(.WIDTH(WIDTH)) u_out (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (wr && wr_route_q[i]),
         .word      (result),
         .out_valid (out_v[i]),
         .out_ready (out_r[i]),
         .out_data  (out_d[i])
      );
   end

endmodule

// File: rtl/dp_cell_chk.sv
module dp_cell_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_load,
   input logic             busy,
   input logic             fire,
   input logic [3:0]       op,
   input logic [1:0]       route,
   input logic             a_valid,
   input logic             a_ready,
   input logic             x_valid,
   input logic             x_ready,
   input logic [WIDTH-1:0] x_data,
   input logic             y_valid,
   input logic             y_ready,
   input logic [WIDTH-1:0] y_data
);

   p_hold_x_r8: assert property (@(posedge clk) disable iff (!rst_n)
      x_valid && !x_ready |=> x_valid && $stable(x_data));

   p_hold_y_r8: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid && !y_ready |=> y_valid && $stable(y_data));

   p_no_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      a_ready && !a_valid |=> a_ready);

   p_consume_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> a_ready);

   p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cfg_load |=> $stable(op) && $stable(route));

   p_end_of_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(x_valid) |-> $past(busy));

   p_route_x_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(x_valid) |-> route[0]);

   p_route_y_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(y_valid) |-> route[1]);

endmodule

bind dp_cell dp_cell_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_load (cfg_load),
   .busy     (busy_q),
   .fire     (fire),
   .op       (cfg_op_q),
   .route    (cfg_route_q),
   .a_valid  (a_valid),
   .a_ready  (a_ready),
   .x_valid  (x_valid),
   .x_ready  (x_ready),
   .x_data   (x_data),
   .y_valid  (y_valid),
   .y_ready  (y_ready),
   .y_data   (y_data)
);

// File: tb/sim_dp_cell.sv
module sim_dp_cell;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 32;
   localparam int AS = 4;
   localparam int MS = 22;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_load = 1'b0;
   logic [3:0] cfg_op = '0;
   logic [1:0] cfg_route = 2'b01;
   logic a_valid = 1'b0, b_valid = 1'b0;
   logic [W-1:0] a_data = '0, b_data = '0;
   logic x_ready = 1'b1, y_ready = 1'b1;
   logic a_ready, b_ready, x_valid, y_valid;
   logic [W-1:0] x_data, y_data;

   int n_chk = 0, n_fail = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dp_cell #(.WIDTH(W), .ALU_STEPS(AS), .MUL_STEPS(MS), .MUL_BPS(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_op(cfg_op),
      .cfg_route(cfg_route), .a_valid(a_valid), .a_ready(a_ready),
      .a_data(a_data), .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
      .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data),
      .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data)
   );

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
         finish_run();
      end
   end

   function automatic logic [W-1:0] pat(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'hFFFF_FFFF;
         3: return 32'h8000_0000;
         4: return 32'h7FFF_FFFF;
         5: return 32'h1234_5678;
         6: return 32'hDEAD_BEEF;
         default: return 32'hA5A5_A5A5;
      endcase
   endfunction

   function automatic logic [W-1:0] expect_of(input logic [3:0] op,
                                              input logic [W-1:0] a,
                                              input logic [W-1:0] b);
      case (op)
         4'd1: return a + b;
         4'd2: return a - b;
         4'd3: return a & b;
         4'd4: return a | b;
         4'd5: return a ^ b;
         4'd6: return a;
         default: return a * b;
      endcase
   endfunction

   task automatic load_cfg(input logic [3:0] op, input logic [1:0] rt);
      @(negedge clk);
      cfg_load = 1'b1; cfg_op = op; cfg_route = rt;
      @(posedge clk);
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic send_ab(input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      a_valid = 1'b1; a_data = a; b_valid = 1'b1; b_data = b;
      @(posedge clk);
      @(negedge clk);
      a_valid = 1'b0; b_valid = 1'b0;
   endtask

   task automatic send_a(input logic [W-1:0] a);
      @(negedge clk);
      a_valid = 1'b1; a_data = a;
      @(posedge clk);
      @(negedge clk);
      a_valid = 1'b0;
   endtask

   task automatic send_b(input logic [W-1:0] b);
      @(negedge clk);
      b_valid = 1'b1; b_data = b;
      @(posedge clk);
      @(negedge clk);
      b_valid = 1'b0;
   endtask

   // counts edges, from the current negedge, until x_valid is seen
   task automatic wait_x(output int n, output logic [W-1:0] d, output logic yv,
                         output logic [W-1:0] yd);
      n = 0;
      while (!x_valid && n < 100) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      d = x_data; yv = y_valid; yd = y_data;
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) @(negedge clk);
   endtask

   int n, n2;
   logic [W-1:0] d, yd;
   logic yv;
   logic seen;

   initial begin
      idle(3);
      chk("R1", "x_valid after reset", W'(x_valid), 0);
      chk("R1", "y_valid after reset", W'(y_valid), 0);
      chk("R1", "a_ready after reset", W'(a_ready), 1);
      chk("R1", "b_ready after reset", W'(b_ready), 1);
      rst_n = 1'b1;
      idle(2);

      // R12: reset operator is the no-op, operands stay held
      send_ab(32'd40, 32'd2);
      seen = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (x_valid || y_valid) seen = 1'b1;
      end
      chk("R12", "no result under no-op", W'(seen), 0);
      chk("R12", "a held under no-op", W'(a_ready), 0);
      chk("R12", "b held under no-op", W'(b_ready), 0);
      load_cfg(4'd9, 2'b01);
      seen = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (x_valid) seen = 1'b1;
      end
      chk("R12", "no result under code 9", W'(seen), 0);
      load_cfg(4'd1, 2'b01);
      wait_x(n, d, yv, yd);
      chk("R12", "held operands used later", d, 32'd42);
      idle(2);

      // R2, R3, R4, R5, R11: sweep operators, operands and routes
      for (int op = 1; op <= 7; op++) begin
         if (op == 6) continue;
         for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
               logic [1:0] rt;
               rt = 2'((i + j) % 3 + 1);
               load_cfg(4'(op), rt);
               send_ab(pat(i), pat(j) ^ W'(j * 32'h0101_0101));
               if (rt[0]) begin
                  wait_x(n, d, yv, yd);
                  chk(op == 7 ? "R4" : "R2", "x result", d,
                      expect_of(4'(op), pat(i), pat(j) ^ W'(j * 32'h0101_0101)));
                  chk(op == 7 ? "R5" : "R3", "latency", W'(n), W'((op == 7 ? MS : AS) + 1));
                  chk("R11", "y matches route", W'(yv), W'(rt[1]));
                  if (rt[1]) chk("R11", "y result", yd, d);
               end else begin
                  n = 0;
                  while (!y_valid && n < 100) begin
                     @(posedge clk); n++; @(negedge clk);
                  end
                  chk("R11", "x unselected", W'(x_valid), 0);
                  chk(op == 7 ? "R4" : "R2", "y result", y_data,
                      expect_of(4'(op), pat(i), pat(j) ^ W'(j * 32'h0101_0101)));
               end
               idle(1);
            end
         end
      end

      // R6: a single operand never fires
      load_cfg(4'd2, 2'b01);
      send_a(32'd100);
      seen = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (x_valid) seen = 1'b1;
      end
      chk("R6", "no fire on A alone", W'(seen), 0);
      chk("R6", "A ready low while held", W'(a_ready), 0);
      send_b(32'd1);
      wait_x(n, d, yv, yd);
      chk("R6", "result after B", d, 32'd99);
      chk("R6", "latency from B", W'(n), W'(AS + 1));
      chk("R6", "A ready after consume", W'(a_ready), 1);
      idle(2);

      // R9: pass needs only A and leaves B alone
      load_cfg(4'd6, 2'b11);
      send_a(32'hCAFE_0001);
      wait_x(n, d, yv, yd);
      chk("R9", "pass value", d, 32'hCAFE_0001);
      chk("R9", "pass latency", W'(n), W'(AS + 1));
      chk("R9", "pass to y", yd, 32'hCAFE_0001);
      chk("R9", "b untouched", W'(b_ready), 1);
      idle(2);

      // R7: operands arriving while busy wait; back-to-back multiply spacing
      load_cfg(4'd7, 2'b01);
      send_ab(32'd3, 32'd5);
      send_ab(32'd6, 32'd7);
      chk("R7", "second A held during busy", W'(a_ready), 0);
      wait_x(n, d, yv, yd);
      chk("R7", "first product", d, 32'd15);
      @(posedge clk);
      @(negedge clk);
      wait_x(n2, d, yv, yd);
      chk("R7", "second product", d, 32'd42);
      chk("R7", "product spacing", W'(n2 + 1), W'(MS + 2));
      idle(2);

      // R10: configuration load during busy is ignored
      load_cfg(4'd7, 2'b01);
      send_ab(32'd9, 32'd9);
      idle(3);
      load_cfg(4'd1, 2'b11);
      wait_x(n, d, yv, yd);
      chk("R10", "still multiply", d, 32'd81);
      chk("R10", "route unchanged", W'(yv), 0);
      idle(1);
      send_ab(32'd6, 32'd7);
      wait_x(n, d, yv, yd);
      chk("R10", "next still multiply", d, 32'd42);
      idle(2);
      load_cfg(4'd1, 2'b11);
      send_ab(32'd6, 32'd7);
      wait_x(n, d, yv, yd);
      chk("R10", "idle load takes effect", d, 32'd13);
      chk("R10", "idle route takes effect", W'(yv), 1);
      idle(2);

      // R8: output stall holds data and blocks firing
      load_cfg(4'd1, 2'b01);
      x_ready = 1'b0;
      send_ab(32'd5, 32'd7);
      wait_x(n, d, yv, yd);
      chk("R8", "stalled result", d, 32'd12);
      send_ab(32'd3, 32'd4);
      idle(12);
      chk("R8", "valid held", W'(x_valid), 1);
      chk("R8", "data held", x_data, 32'd12);
      chk("R8", "operands unconsumed", W'(a_ready), 0);
      x_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wait_x(n, d, yv, yd);
      chk("R8", "next after release", d, 32'd7);
      idle(2);

      finish_run();
   end

endmodule